// File: doc/BRIEF.md
# Range to Ternary Prefix Word Generator

The block turns an inclusive numeric range into the shortest list of ternary value/mask pairs that, taken together, match every key inside the range and no key outside it. Both bounds arrive packed in one road word. After a start strobe the block walks upward from the lower bound. Each clock it emits one pair that describes the largest power-of-two block aligned to its own size which still fits below the upper bound. Each pair is a fixed prefix followed by don't-care low bits. The pairs go straight into a ternary CAM load port, so later lookups of a key report whether the key lies in the range.

A mask bit of 1 marks a don't-care position. A range of W-bit keys needs at most 2W-2 words. A full-width range needs a single all-don't-care word. A reversed bound pair produces no words and only a done pulse.

Top module: `tern_range_gen`

## Requirements
- R1: road_i bits [21:11] hold the upper bound and bits [10:0] hold the lower bound. A start_i sampled high while the block is idle captures both bounds at that edge.
- R2: In every emitted word, mask_o is a run of ones from bit 0 upward (possibly empty or full), and value_o is zero in every bit where mask_o is one.
- R3: The first word's value_o equals the lower bound. Each later word's value_o equals the previous word's (value_o | mask_o) + 1. The last word's (value_o | mask_o) equals the upper bound, so the words cover the range exactly, with no gap and no overlap.
- R4: Each word is the largest aligned block that fits, so the word count is the minimum possible (for example 1..2046 gives 20 words, 0..2047 gives one word with mask 0x7FF, 100..200 gives 6 words).
- R5: word_valid_o is high in every cycle from the cycle after the accepting edge through the last word, one word per cycle.
- R6: done_o is high for exactly one cycle. For a non-empty range it coincides with the last word's word_valid_o.
- R7: When the lower bound exceeds the upper bound, no word is emitted and done_o is high, with word_valid_o low, in the cycle after the accepting edge.
- R8: start_i is ignored while words are being emitted or done_o is high, including during the last word's cycle. The captured bounds and the word sequence are unaffected.
- R9: While rst_ni is low, word_valid_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin decomposing road_i |
| road_i | input | 22 | Packed bounds: upper in [21:11], lower in [10:0] |
| word_valid_o | output | 1 | value_o and mask_o carry a word this cycle |
| value_o | output | 11 | Fixed bits of the ternary word |
| mask_o | output | 11 | Don't-care bits of the word (1 = don't care) |
| done_o | output | 1 | One-cycle pulse that ends a decomposition |

## Verification
Completion and the last word share a cycle. A new start request can also land in that same cycle, or anywhere in the emission window. The bench holds start_i high, and changes road_i, from the second emission cycle through the edge that closes the last word. Both arrangements pass only if done_o appears exactly with the final word, the sequence still follows the first road, and the cycle after done_o shows neither a word nor a second done. The reversed-bound case is judged the same way, with start_i held through the done cycle.

// File: rtl/tern_range_pkg.sv
package tern_range_pkg;
  localparam int unsigned DEF_KEY_W = 11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_NONE = 2'd2
  } gen_state_e;
endpackage

// File: rtl/tern_range_sel.sv
// Picks the largest aligned block starting at cur_i that stays within hi_i.
module tern_range_sel #(
  parameter int unsigned KEY_W = tern_range_pkg::DEF_KEY_W
) (
  input  logic [KEY_W-1:0] cur_i,
  input  logic [KEY_W-1:0] hi_i,
  output logic [KEY_W-1:0] mask_o,
  output logic [KEY_W-1:0] next_o,
  output logic             last_o
);
  localparam logic [KEY_W-1:0] ALL_ONES = '1;

  logic [KEY_W-1:0] span_end;

  always_comb begin
    mask_o = '0;
    // fitting is monotonic in block size, so the last hit is the largest
    for (int unsigned k = 0; k <= KEY_W; k++) begin
      logic [KEY_W-1:0] cand;
      cand = ~(ALL_ONES << k);
      if (((cur_i & cand) == '0) && ((cur_i | cand) <= hi_i)) begin
        mask_o = cand;
      end
    end
  end

  // aligned block: end is an OR, no carry chain
  assign span_end = cur_i | mask_o;
  assign last_o   = (span_end == hi_i);
  assign next_o   = span_end + KEY_W'(1);
endmodule

// File: rtl/tern_range_ctrl.sv
module tern_range_ctrl #(
  parameter int unsigned KEY_W = tern_range_pkg::DEF_KEY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [KEY_W-1:0] lo_i,
  input  logic [KEY_W-1:0] hi_i,
  input  logic             last_i,
  input  logic [KEY_W-1:0] next_i,
  output logic [KEY_W-1:0] cur_o,
  output logic [KEY_W-1:0] hi_q_o,
  output logic             emit_o,
  output logic             done_o
);
  import tern_range_pkg::*;

  gen_state_e       state_q;
  logic [KEY_W-1:0] cur_q;
  logic [KEY_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      hi_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cur_q   <= lo_i;
          hi_q    <= hi_i;
          state_q <= (lo_i > hi_i) ? ST_NONE : ST_EMIT;
        end
        ST_EMIT: begin
          if (last_i) state_q <= ST_IDLE;
          else        cur_q   <= next_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cur_o  = cur_q;
  assign hi_q_o = hi_q;
  assign emit_o = (state_q == ST_EMIT);
  assign done_o = (state_q == ST_NONE) || (emit_o && last_i);

  // R1
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !emit_o && !done_o && lo_i <= hi_i) |=> (emit_o && cur_o == $past(lo_i)));
  // R7
  empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !emit_o && !done_o && lo_i > hi_i) |=> (done_o && !emit_o));
  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_o && !last_i) |=> (emit_o && hi_q_o == $past(hi_q_o)));
endmodule

// File: rtl/tern_range_gen.sv
module tern_range_gen #(
  parameter int unsigned KEY_W = tern_range_pkg::DEF_KEY_W,
  localparam int unsigned ROAD_W = 2 * KEY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ROAD_W-1:0] road_i,
  output logic              word_valid_o,
  output logic [KEY_W-1:0]  value_o,
  output logic [KEY_W-1:0]  mask_o,
  output logic              done_o
);
  logic [KEY_W-1:0] lo_w, hi_w, cur_w, hi_q_w, next_w, mask_w;
  logic             last_w, emit_w;

  assign hi_w = road_i[ROAD_W-1:KEY_W];
  assign lo_w = road_i[KEY_W-1:0];

  tern_range_ctrl #(.KEY_W(KEY_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .lo_i   (lo_w),
    .hi_i   (hi_w),
    .last_i (last_w),
    .next_i (next_w),
    .cur_o  (cur_w),
    .hi_q_o (hi_q_w),
    .emit_o (emit_w),
    .done_o (done_o)
  );

  tern_range_sel #(.KEY_W(KEY_W)) u_sel (
    .cur_i (cur_w),
    .hi_i  (hi_q_w),
    .mask_o(mask_w),
    .next_o(next_w),
    .last_o(last_w)
  );

  assign word_valid_o = emit_w;
  assign value_o      = cur_w;
  assign mask_o       = mask_w;

  // R2
  mask_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> ((value_o & mask_o) == '0));
  // R2
  mask_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (((mask_o + KEY_W'(1)) & mask_o) == '0));
  // R3
  contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !done_o) |=> (word_valid_o && value_o == $past(value_o | mask_o) + KEY_W'(1)));
  // R3
  end_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && done_o) |-> ((value_o | mask_o) == hi_q_w));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/tern_range_gen_tb.sv
`timescale 1ns/1ps
module tern_range_gen_tb_top;
  localparam int KEY_W = 11;
  localparam int NV = 11;
  // lower, upper, word count, first mask
  localparam int unsigned VEC [NV][4] = '{
    '{5,    5,    1,  0},
    '{0,    2047, 1,  2047},
    '{1,    2046, 20, 0},
    '{4,    11,   2,  3},
    '{3,    12,   4,  0},
    '{0,    1023, 1,  1023},
    '{1024, 2047, 1,  1023},
    '{7,    8,    2,  0},
    '{100,  200,  6,  3},
    '{2047, 2047, 1,  0},
    '{10,   9,    0,  0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2*KEY_W-1:0] road = '0;
  logic word_valid, done;
  logic [KEY_W-1:0] value, mask;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  tern_range_gen #(.KEY_W(KEY_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .road_i(road),
    .word_valid_o(word_valid), .value_o(value), .mask_o(mask), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_range(input int lo, input int hi, input int exp_cnt,
                           input int exp_fmask, input bit hold);
    int cnt = 0;
    int exp_next = lo;
    bit fin = 0;
    @(negedge clk);
    road  = {hi[KEY_W-1:0], lo[KEY_W-1:0]};
    start = 1'b1;
    @(negedge clk);
    if (hold) road = ~road;  // R8: new request while busy
    else      start = 1'b0;
    for (int cyc = 0; cyc < 40 && !fin; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (word_valid) begin
        if (cnt == 0) begin
          chk("R3 first value", int'(value), lo);
          chk("R4 first mask", int'(mask), exp_fmask);
        end else begin
          chk("R3 contiguous", int'(value), exp_next);
        end
        chk("R2 aligned", int'(value & mask), 0);
        chk("R2 mask shape", int'((mask + 11'd1) & mask), 0);
        exp_next = int'(value | mask) + 1;
        cnt++;
        if (done) begin
          chk("R3 last end", int'(value | mask), hi);
          fin = 1;
        end
      end else if (done) begin
        chk("R7 empty range", exp_cnt, 0);
        chk("R7 done cycle", cyc, 0);
        fin = 1;
      end else begin
        chk("R5 word gap", 0, 1);
      end
    end
    chk("R6 done seen", int'(fin), 1);
    chk("R4 word count", cnt, exp_cnt);
    @(negedge clk);
    chk("R6 done one cycle", int'(done), 0);
    chk("R8 start ignored", int'(word_valid), 0);
    start = 1'b0;
  endtask

  initial begin
    #1;
    // R9
    chk("R9 reset valid", int'(word_valid), 0);
    chk("R9 reset done", int'(done), 0);
    repeat (2) @(negedge clk);
    start = 1'b1;  // ignored under reset
    road  = {11'd20, 11'd10};
    @(negedge clk);
    chk("R9 start in reset", int'(word_valid | done), 0);
    start = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      run_range(int'(VEC[i][0]), int'(VEC[i][1]), int'(VEC[i][2]), int'(VEC[i][3]), 1'b0);
    end
    // R8: start held and road changed through the last word's closing edge
    run_range(100, 200, 6, 3, 1'b1);
    run_range(1, 2046, 20, 0, 1'b1);
    run_range(10, 9, 0, 0, 1'b1);
    // R1: bound halves are not swapped (upper half greater -> words)
    run_range(0, 1, 1, 1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule